// File: doc/BRIEF.md
# Serial Receiver with Majority-Vote Bit Decisions

This block receives asynchronous serial words on a single line. While the line is quiet it keeps an external bit-rate tick generator stopped and cleared. When it sees the line go low it releases that generator, so the first bit tick arrives one full bit period after the falling edge. Every bit cell, including the start bit and the stop bits, is resolved by a counting filter. The filter is fed by a 16x oversampling tick and reset at every bit tick.

A bit is read as 0 only if enough low samples build up within its cell. This rejects short spikes on the line. Eight data bits are shifted in, least significant first. After the stop bit or bits check out, the word is placed, zero-extended, on a 16-bit output with a one-cycle completion pulse. A start bit that resolves high is dropped as a glitch. A stop bit that resolves low is a framing error: the word is discarded and no pulse is raised.

Top module: `uart_majority_rx`

## Requirements
- R1: After synchronous reset, `word_o` is 0, `done_o` is 0 and `tick_hold_o` is 1.
- R2: `tick_hold_o` stays 1 while the receiver is idle and the line is high. In the cycle after the line is sampled low in idle, `tick_hold_o` is 0 and stays 0 until the frame ends.
- R3: Each bit cell is resolved as 0 when at least 9 of the oversampling ticks inside the cell saw the line low, and as 1 otherwise. The count restarts at each bit tick, and an oversampling tick that coincides with a bit tick is not counted.
- R4: A start bit that resolves as 1 returns the receiver to idle (`tick_hold_o` back to 1) without a completion pulse and without changing `word_o`.
- R5: Data bits are taken least significant first. The 8-bit result appears on `word_o[7:0]`, and `word_o[15:8]` is always 0.
- R6: With `two_stop_i` = 0, one stop bit is checked. With `two_stop_i` = 1, two are checked. `done_o` rises in the cycle after the bit tick that ends the last stop bit.
- R7: `done_o` is high for exactly one cycle per accepted word, and `word_o` changes only in a cycle where `done_o` is high.
- R8: A stop bit that resolves as 0 (either the first or the second) discards the word: no pulse is raised, `word_o` keeps its value, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle pulse at the end of each bit period |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| two_stop_i | input | 1 | 0: one stop bit, 1: two stop bits |
| rx_i | input | 1 | Serial line, idle high |
| word_o | output | 16 | Last accepted word, zero-extended |
| done_o | output | 1 | One-cycle pulse when a word is accepted |
| tick_hold_o | output | 1 | High while idle: stop and clear the tick generator |

## Verification
The assertions check the cycle-level rules on every cycle:
- the hold output releases right after a low line sample in idle;
- the completion pulse lasts one cycle and only follows a bit tick;
- the output word moves only with that pulse, and its upper byte stays zero.

Only the bench scenarios can show the things that depend on whole frames:
- the majority decision at sample counts either side of the threshold, including tolerance to random noise bursts;
- least-significant-first assembly;
- discarding of glitched starts and of frames whose first or second stop bit is bad.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam int MRX_DATA_BITS = 8;
    localparam int MRX_WORD_W    = 16;
    localparam int MRX_OS_RATE   = 16;
    localparam int MRX_THRESH    = 9;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    typedef struct packed {
        logic clear;    // restart filter count
        logic capture;  // filter may count samples
        logic shift;    // push resolved bit into shifter
        logic commit;   // publish assembled word
    } rx_ctl_t;

    // true when this state's bit tick closes the frame successfully
    function automatic logic last_stop(input rx_state_t st, input logic two_stop);
        return (st == RX_STOP2) || (st == RX_STOP1 && !two_stop);
    endfunction

endpackage

// File: rtl/mrx_majority_filter.sv
module mrx_majority_filter #(
    parameter int RATE   = 16,
    parameter int THRESH = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic capture_i,
    input  logic sample_i,
    input  logic line_i,
    output logic level_o
);
    localparam int CW = $clog2(RATE + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            low_cnt <= '0;
        end else if (capture_i && sample_i && !line_i && low_cnt < CW'(THRESH)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign level_o = !(low_cnt >= CW'(THRESH));

endmodule

// File: rtl/mrx_shifter.sv
module mrx_shifter #(
    parameter int BITS  = 8,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             commit_i,
    output logic [OUT_W-1:0] word_o
);
    localparam int PAD = OUT_W - BITS;

    logic [BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            word_o <= '0;
        end else begin
            if (shift_i) begin
                sh <= {bit_i, sh[BITS-1:1]};
            end
            if (commit_i) begin
                word_o <= {{PAD{1'b0}}, sh};
            end
        end
    end

endmodule

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
    import mrx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rx_i,
    input  logic    bit_tick_i,
    input  logic    level_i,
    input  logic    two_stop_i,
    output rx_ctl_t ctl_o,
    output logic    hold_o,
    output logic    done_o
);
    localparam int BCW = (BITS > 1) ? $clog2(BITS) : 1;

    rx_state_t      st;
    logic [BCW-1:0] bcnt;
    logic           finish;

    always_comb begin
        finish        = bit_tick_i && level_i && last_stop(st, two_stop_i);
        ctl_o.clear   = (st == RX_IDLE) || bit_tick_i;
        ctl_o.capture = (st != RX_IDLE);
        ctl_o.shift   = bit_tick_i && (st == RX_DATA);
        ctl_o.commit  = finish;
    end

    assign hold_o = (st == RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            bcnt   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish;
            unique case (st)
                RX_IDLE: begin
                    bcnt <= '0;
                    if (!rx_i) st <= RX_START;
                end
                RX_START: begin
                    if (bit_tick_i) st <= level_i ? RX_IDLE : RX_DATA;
                end
                RX_DATA: begin
                    if (bit_tick_i) begin
                        if (bcnt == BCW'(BITS - 1)) st <= RX_STOP1;
                        else bcnt <= bcnt + 1'b1;
                    end
                end
                RX_STOP1: begin
                    if (bit_tick_i) begin
                        if (!level_i)        st <= RX_IDLE;
                        else if (two_stop_i) st <= RX_STOP2;
                        else                 st <= RX_IDLE;
                    end
                end
                RX_STOP2: begin
                    if (bit_tick_i) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_majority_rx.sv
module uart_majority_rx
    import mrx_pkg::*;
#(
    parameter int DATA_BITS = MRX_DATA_BITS,
    parameter int WORD_W    = MRX_WORD_W,
    parameter int OS_RATE   = MRX_OS_RATE,
    parameter int THRESH    = MRX_THRESH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick_i,
    input  logic              os_tick_i,
    input  logic              two_stop_i,
    input  logic              rx_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o,
    output logic              tick_hold_o
);
    rx_ctl_t ctl;
    logic    level;

    mrx_majority_filter #(.RATE(OS_RATE), .THRESH(THRESH)) filt_i (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (ctl.clear),
        .capture_i (ctl.capture),
        .sample_i  (os_tick_i),
        .line_i    (rx_i),
        .level_o   (level)
    );

    mrx_ctrl #(.BITS(DATA_BITS)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .rx_i       (rx_i),
        .bit_tick_i (bit_tick_i),
        .level_i    (level),
        .two_stop_i (two_stop_i),
        .ctl_o      (ctl),
        .hold_o     (tick_hold_o),
        .done_o     (done_o)
    );

    mrx_shifter #(.BITS(DATA_BITS), .OUT_W(WORD_W)) shf_i (
        .clk      (clk),
        .rst      (rst),
        .shift_i  (ctl.shift),
        .bit_i    (level),
        .commit_i (ctl.commit),
        .word_o   (word_o)
    );

endmodule

// File: rtl/mrx_rx_checker.sv
module mrx_rx_checker #(
    parameter int DATA_BITS = 8,
    parameter int WORD_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_i,
    input logic              bit_tick_i,
    input logic [WORD_W-1:0] word_o,
    input logic              done_o,
    input logic              tick_hold_o
);
    p_start_release_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_hold_o && !rx_i) |=> !tick_hold_o);

    p_idle_keeps_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_hold_o && rx_i) |=> tick_hold_o);

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        word_o[WORD_W-1:DATA_BITS] == '0);

    p_done_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(bit_tick_i));

    p_done_back_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> tick_hold_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_word_moves_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(word_o));

endmodule

bind uart_majority_rx mrx_rx_checker #(.DATA_BITS(DATA_BITS), .WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (rx_i),
    .bit_tick_i  (bit_tick_i),
    .word_o      (word_o),
    .done_o      (done_o),
    .tick_hold_o (tick_hold_o)
);

// File: tb/uart_majority_rx_tb_top.sv
`timescale 1ns/1ps
module uart_majority_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick_i = 1'b0;
    logic        os_tick_i = 1'b0;
    logic        two_stop_i = 1'b0;
    logic        rx_i = 1'b1;
    logic [15:0] word_o;
    logic        done_o;
    logic        tick_hold_o;

    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    int pulse_bad = 0;
    int stab_bad = 0;
    int cyc = 0;
    logic [15:0] last_word = '0;
    logic [15:0] prev_word = '0;
    logic        prev_done = 1'b0;
    logic [5:0]  gcnt = '0;

    always #10 clk = ~clk;   // 50 MHz

    uart_majority_rx dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_tick_i  (bit_tick_i),
        .os_tick_i   (os_tick_i),
        .two_stop_i  (two_stop_i),
        .rx_i        (rx_i),
        .word_o      (word_o),
        .done_o      (done_o),
        .tick_hold_o (tick_hold_o)
    );

    // Tick source model: 64 clocks per bit, 16 samples per bit, cleared while held.
    always @(negedge clk) begin
        if (rst || tick_hold_o) begin
            gcnt       = '0;
            os_tick_i  = 1'b0;
            bit_tick_i = 1'b0;
        end else begin
            gcnt       = gcnt + 1'b1;
            os_tick_i  = (gcnt[1:0] == 2'd1);
            bit_tick_i = (gcnt == 6'd63);
        end
    end

    // Output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                done_cnt++;
                last_word = word_o;
                if (prev_done) pulse_bad++;
            end else if (word_o !== prev_word) begin
                stab_bad++;
            end
            prev_done = done_o;
            prev_word = word_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] exp_word(input logic [7:0] b);
        return {8'h00, b};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive n bit cells from v (cell 0 first). One cell may carry an inverted
    // burst of blen cycles from cycle 8; noisy adds short random bursts.
    task automatic drive_cells(input logic [11:0] v, input int n, input int bcell,
                               input int blen, input bit noisy);
        for (int k = 0; k < n; k++) begin
            int o1;
            int o2;
            o1 = noisy ? 4 + int'($urandom % 52) : -100;
            o2 = (noisy && ($urandom % 2) == 1) ? 4 + int'($urandom % 52) : -100;
            for (int j = 0; j < 64; j++) begin
                logic val;
                val = v[k];
                if (k == bcell && j >= 8 && j < 8 + blen) val = !val;
                if (j >= o1 && j < o1 + 3) val = !val;
                if (j >= o2 && j < o2 + 3) val = !val;
                if (k == 0 && j == 1)
                    chk(tick_hold_o == 1'b0, "R2 hold released after start", tick_hold_o, 0);
                rx_i = val;
                @(negedge clk);
            end
        end
        rx_i = 1'b1;
    endtask

    task automatic good_frame(input logic [7:0] b, input bit two, input int bcell,
                              input int blen, input bit noisy, input logic [7:0] expb,
                              input string req);
        int d0;
        logic [11:0] v;
        two_stop_i = two;
        chk(tick_hold_o == 1'b1, "R2 hold while idle", tick_hold_o, 1);
        d0 = done_cnt;
        v  = {2'b11, b, 1'b0};
        drive_cells(v, two ? 11 : 10, bcell, blen, noisy);
        repeat (3) @(negedge clk);
        chk(done_cnt - d0 == 1, req, done_cnt - d0, 1);
        chk(last_word == exp_word(expb), req, last_word, exp_word(expb));
    endtask

    task automatic bad_frame(input logic [11:0] v, input int n, input bit two,
                             input string req);
        int d0;
        logic [15:0] w0;
        two_stop_i = two;
        d0 = done_cnt;
        w0 = word_o;
        drive_cells(v, n, -1, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0, req, done_cnt - d0, 0);
        chk(word_o == w0, req, word_o, w0);
        chk(tick_hold_o == 1'b1, req, tick_hold_o, 1);
    endtask

    initial begin
        int d0;
        logic [15:0] w0;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(word_o == 16'h0, "R1 word after reset", word_o, 0);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
        chk(tick_hold_o == 1'b1, "R1 hold after reset", tick_hold_o, 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(tick_hold_o == 1'b1, "R2 idle with high line", tick_hold_o, 1);

        // R5 ordering, R6 one and two stop bits
        good_frame(8'h00, 1'b0, -1, 0, 1'b0, 8'h00, "R5 word 00");
        good_frame(8'hFF, 1'b0, -1, 0, 1'b0, 8'hFF, "R5 word FF");
        good_frame(8'h01, 1'b0, -1, 0, 1'b0, 8'h01, "R5 lsb first 01");
        good_frame(8'hA5, 1'b1, -1, 0, 1'b0, 8'hA5, "R6 two stop A5");
        good_frame(8'h80, 1'b1, -1, 0, 1'b0, 8'h80, "R6 two stop 80");

        // R3 majority boundary: bit 2 is cell 3
        good_frame(8'hFF, 1'b0, 3, 24, 1'b0, 8'hFF, "R3 6 low samples read 1");
        good_frame(8'h00, 1'b0, 3, 24, 1'b0, 8'h00, "R3 10 low samples read 0");
        good_frame(8'hFF, 1'b0, 3, 48, 1'b0, 8'hFB, "R3 12 low samples read 0");

        // R4 start glitch: 20 low cycles give 5 low samples
        d0 = done_cnt;
        w0 = word_o;
        rx_i = 1'b0;
        repeat (20) @(negedge clk);
        rx_i = 1'b1;
        repeat (100) @(negedge clk);
        chk(done_cnt == d0, "R4 glitch gives no done", done_cnt - d0, 0);
        chk(word_o == w0, "R4 glitch keeps word", word_o, w0);
        chk(tick_hold_o == 1'b1, "R4 glitch returns idle", tick_hold_o, 1);
        good_frame(8'h3C, 1'b0, -1, 0, 1'b0, 8'h3C, "R4 frame after glitch");

        // R8 framing errors
        bad_frame({2'b10, 8'h5A, 1'b0}, 10, 1'b0, "R8 bad single stop");
        good_frame(8'h66, 1'b0, -1, 0, 1'b0, 8'h66, "R8 recovery");
        bad_frame({2'b01, 8'hC3, 1'b0}, 11, 1'b1, "R8 bad second stop");
        good_frame(8'h99, 1'b1, -1, 0, 1'b0, 8'h99, "R8 recovery two stop");

        // Random frames with noise bursts (R3, R5, R6)
        for (int i = 0; i < 30; i++) begin
            logic [7:0] b;
            bit two;
            int gap;
            b   = 8'($urandom);
            two = 1'($urandom);
            gap = int'($urandom % 20);
            repeat (gap) @(negedge clk);
            good_frame(b, two, -1, 0, 1'b1, b, "R3 random noisy frame");
        end

        chk(pulse_bad == 0, "R7 done pulse width", pulse_bad, 0);
        chk(stab_bad == 0, "R7 word changes only with done", stab_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule